// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This peripheral sits on an 8-bit processor bus and exposes three 8-bit parallel ports (A, B and C) plus one control register. A processor selects the device with an active-low chip select and picks one of four locations with two address bits. It then reads or writes with active-low read and write strobes. Port A and port B each have a single direction setting. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction.

A write to the control location does one of two things, depending on bit 7 of the data. With bit 7 set, the word replaces the whole port configuration and clears every output latch. With bit 7 clear, the word sets or clears one chosen bit of the port C latch and leaves everything else alone. The mode fields for strobed handshake and bidirectional operation are stored and read back, but the ports always behave as plain latched outputs or live inputs.

The bus is modelled as separate read-data and drive-enable outputs, so the surrounding chip can build its own tri-state or multiplexed bus. Each port likewise has a latch output and a drive-enable output.

Top module: `ppi3_top`

## Requirements
- R1: With `cs_n` low, `addr` 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. With `cs_n` high, a write strobe changes no latch and no configuration.
- R2: `dout_en` is 1 exactly while `cs_n` and `rd_n` are both 0. While `dout_en` is 0, `dout` is 00h.
- R3: A control write with bit 7 = 1 sets the port directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7..4 and bit 0 sets port C bits 3..0. `pa_oe`, `pb_oe` and the `pc_oe` nibbles are 1 for output.
- R4: In a configuration word, bits 6..5 (group A mode) and bit 2 (group B mode) are stored and returned by a read of the control register as {1, bits 6..0}. Any mode value leaves the ports working as plain input or output.
- R5: A configuration write clears the port A, B and C latches to 00h.
- R6: A control write with bit 7 = 0 loads bit 0 of the word into port C latch bit number bits 3..1. No other port C bit changes, and the port A and B latches and the configuration are unaffected.
- R7: After reset, every drive enable is 0, every latch is 00h and the control register reads 9Bh.
- R8: A port read returns the latch value for bits configured as output and the live pin value for bits configured as input. Port C is chosen per nibble.
- R9: A write takes effect once per strobe: on the first clock edge at which `cs_n` and `wr_n` are both sampled low. Data changes while the strobe stays low are ignored.
- R10: A port C bit set/reset updates the latch even when that nibble is configured as input; the new value appears on `pc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location select |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor |
| dout_en | output | 1 | Read data drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
Configuration words are tried in several forms: all outputs (80h), port A input with B and C output (90h), a split port C (88h), and words with non-basic mode fields (E4h). Each is followed by port writes and reads, which separates the direction bits from one another and shows whether a read takes the latch or the pin. Set and clear commands target distinct port C bits against distinct A and B patterns, which shows whether a command leaks into a neighbouring bit or port. A strobe held low while the data changes, and a strobe with chip select high, separate edge-triggered, level-triggered and undecoded write capture.

// File: rtl/ppi3_pkg.sv
package ppi3_pkg;

    localparam int PORT_W = 8;
    localparam int IDX_W  = $clog2(PORT_W);

    typedef enum logic [1:0] {
        LOC_PA   = 2'd0,
        LOC_PB   = 2'd1,
        LOC_PC   = 2'd2,
        LOC_CTRL = 2'd3
    } loc_e;

    // packed to match bits 6..0 of the configuration word
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_is_in;
        logic       chi_is_in;
        logic       grp_b_mode;
        logic       b_is_in;
        logic       clo_is_in;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        loc_e              loc;
        logic [PORT_W-1:0] data;
    } wr_evt_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             val;
    } bitcmd_t;

    function automatic cfg_t cfg_after_reset();
        cfg_t c;
        c.grp_a_mode = 2'b00;
        c.a_is_in    = 1'b1;
        c.chi_is_in  = 1'b1;
        c.grp_b_mode = 1'b0;
        c.b_is_in    = 1'b1;
        c.clo_is_in  = 1'b1;
        return c;
    endfunction

    function automatic bitcmd_t decode_bitcmd(input logic [PORT_W-1:0] w);
        bitcmd_t b;
        b.idx = w[IDX_W:1];
        b.val = w[0];
        return b;
    endfunction

    function automatic logic [PORT_W-1:0] pick_bits(
        input logic [PORT_W-1:0] is_in,
        input logic [PORT_W-1:0] pins,
        input logic [PORT_W-1:0] latch
    );
        return (is_in & pins) | (~is_in & latch);
    endfunction

endpackage

// File: rtl/ppi3_bus_if.sv
module ppi3_bus_if
    import ppi3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] din,
    output wr_evt_t           evt,
    output logic              rd_active
);
    logic wr_lvl;
    logic wr_lvl_q;

    assign wr_lvl    = ~cs_n & ~wr_n;
    assign rd_active = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) wr_lvl_q <= 1'b0;
        else     wr_lvl_q <= wr_lvl;
    end

    always_comb begin
        evt.valid = wr_lvl & ~wr_lvl_q;
        evt.loc   = loc_e'(addr);
        evt.data  = din;
    end

    AST_ONE_SHOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid); // R9

endmodule

// File: rtl/ppi3_ctrl.sv
module ppi3_ctrl
    import ppi3_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_evt_t evt,
    output cfg_t    cfg,
    output logic    cfg_load,
    output logic    bit_load,
    output bitcmd_t bit_cmd
);
    logic to_ctrl;

    assign to_ctrl  = evt.valid && (evt.loc == LOC_CTRL);
    assign cfg_load = to_ctrl &&  evt.data[PORT_W-1];
    assign bit_load = to_ctrl && !evt.data[PORT_W-1];
    assign bit_cmd  = decode_bitcmd(evt.data);

    always_ff @(posedge clk) begin
        if (rst)           cfg <= cfg_after_reset();
        else if (cfg_load) cfg <= cfg_t'(evt.data[PORT_W-2:0]);
    end

    AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.a_is_in && cfg.b_is_in && cfg.chi_is_in && cfg.clo_is_in)); // R7

    AST_BITCMD_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        bit_load |=> $stable(cfg)); // R6

endmodule

// File: rtl/ppi3_latch.sv
module ppi3_latch
    import ppi3_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_BITS = 1'b0,
    localparam int IW      = (W > 1) ? $clog2(W) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ld,
    input  logic [W-1:0]  ld_data,
    input  logic          bit_ld,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    logic [W-1:0] nxt;

    generate
        if (HAS_BITS) begin : g_bits
            always_comb begin
                nxt = q;
                if (clr)         nxt = '0;
                else if (ld)     nxt = ld_data;
                else if (bit_ld) nxt[bit_idx] = bit_val;
            end
        end else begin : g_plain
            logic unused_bits;
            assign unused_bits = bit_ld ^ (^bit_idx) ^ bit_val;
            always_comb begin
                nxt = q;
                if (clr)     nxt = '0;
                else if (ld) nxt = ld_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_CLEAR_ON_CONFIG: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0)); // R5

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (bit_ld && !clr && !ld) |=> ($countones(q ^ $past(q)) <= 1)); // R6

endmodule

// File: rtl/ppi3_top.sv
module ppi3_top
    import ppi3_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [1:0]  addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_en,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic        pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic        pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    localparam int HALF = PORT_W / 2;

    wr_evt_t evt;
    logic    rd_active;
    cfg_t    cfg;
    logic    cfg_load;
    logic    bit_load;
    bitcmd_t bit_cmd;

    ppi3_bus_if u_bus (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (din),
        .evt       (evt),
        .rd_active (rd_active)
    );

    ppi3_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cfg      (cfg),
        .cfg_load (cfg_load),
        .bit_load (bit_load),
        .bit_cmd  (bit_cmd)
    );

    logic [2:0] port_ld;
    logic [2:0] port_bits;
    logic [PORT_W-1:0] latch_q [3];

    assign port_bits = 3'b100;

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_port
            assign port_ld[gi] = evt.valid && (evt.loc == loc_e'(gi));
            ppi3_latch #(
                .W        (PORT_W),
                .HAS_BITS (gi == 2)
            ) u_latch (
                .clk     (clk),
                .rst     (rst),
                .clr     (cfg_load),
                .ld      (port_ld[gi]),
                .ld_data (evt.data),
                .bit_ld  (bit_load && port_bits[gi]),
                .bit_idx (bit_cmd.idx),
                .bit_val (bit_cmd.val),
                .q       (latch_q[gi])
            );
        end
    endgenerate

    assign pa_out = latch_q[0];
    assign pb_out = latch_q[1];
    assign pc_out = latch_q[2];

    logic [PORT_W-1:0] a_in_mask;
    logic [PORT_W-1:0] b_in_mask;
    logic [PORT_W-1:0] c_in_mask;

    assign a_in_mask = {PORT_W{cfg.a_is_in}};
    assign b_in_mask = {PORT_W{cfg.b_is_in}};
    assign c_in_mask = {{HALF{cfg.chi_is_in}}, {HALF{cfg.clo_is_in}}};

    assign pa_oe = ~cfg.a_is_in;
    assign pb_oe = ~cfg.b_is_in;
    assign pc_oe = ~c_in_mask;

    logic [PORT_W-1:0] rd_mux;

    always_comb begin
        unique case (loc_e'(addr))
            LOC_PA:   rd_mux = pick_bits(a_in_mask, pa_in, latch_q[0]);
            LOC_PB:   rd_mux = pick_bits(b_in_mask, pb_in, latch_q[1]);
            LOC_PC:   rd_mux = pick_bits(c_in_mask, pc_in, latch_q[2]);
            default:  rd_mux = {1'b1, cfg};
        endcase
    end

    assign dout_en = rd_active;
    assign dout    = rd_active ? rd_mux : '0;

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 8'h00)); // R2

    AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe))); // R1

    AST_BITCMD_SPARES_AB: assert property (@(posedge clk) disable iff (rst)
        bit_load |=> ($stable(pa_out) && $stable(pb_out))); // R6

endmodule

// File: tb/sim_ppi3_top.sv
module sim_ppi3_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppi3_top u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = dout;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R7 pa_out", pa_out, 8'h00);
        check("R7 pc_out", pc_out, 8'h00);
        check("R7 oe", {pa_oe, pb_oe, 6'b0}, 8'h00);
        check("R7 pc_oe", pc_oe, 8'h00);
        bus_read(2'd3, v);
        check("R7 ctrl readback", v, 8'h9B);
        pa_in = 8'h5C;
        bus_read(2'd0, v);
        check("R8 input pin read", v, 8'h5C);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        bus_write(2'd3, 8'h80);
        check("R3 all out oe", {pa_oe, pb_oe, 6'b0}, 8'hC0);
        check("R3 pc_oe", pc_oe, 8'hFF);
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'h22);
        bus_write(2'd2, 8'h33);
        check("R1 port A", pa_out, 8'h11);
        check("R1 port B", pb_out, 8'h22);
        check("R1 port C", pc_out, 8'h33);
        bus_read(2'd1, v);
        check("R8 output latch read", v, 8'h22);
    endtask

    task automatic t_deselect();
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        check("R1 deselected write", pa_out, 8'h11);
        rd_n = 1'b0;
        #1 check("R2 no drive cs high", {dout_en, 7'b0}, 8'h00);
        check("R2 dout zero", dout, 8'h00);
        rd_n = 1'b1; cs_n = 1'b0;
        #1 check("R2 no drive rd high", {dout_en, 7'b0}, 8'h00);
        cs_n = 1'b1;
    endtask

    task automatic t_cfg90();
        logic [7:0] v;
        bus_write(2'd3, 8'h90);
        check("R5 A cleared", pa_out, 8'h00);
        check("R5 B cleared", pb_out, 8'h00);
        check("R5 C cleared", pc_out, 8'h00);
        check("R3 90h oe", {pa_oe, pb_oe, 6'b0}, 8'h40);
        check("R3 90h pc_oe", pc_oe, 8'hFF);
        pa_in = 8'hA7;
        bus_read(2'd0, v);
        check("R8 A input", v, 8'hA7);
    endtask

    task automatic t_split_c();
        logic [7:0] v;
        bus_write(2'd3, 8'h88);
        check("R3 split pc_oe", pc_oe, 8'h0F);
        bus_write(2'd2, 8'hA5);
        pc_in = 8'h3C;
        bus_read(2'd2, v);
        check("R8 split C read", v, 8'h35);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        bus_write(2'd3, 8'hE4);
        bus_read(2'd3, v);
        check("R4 mode readback", v, 8'hE4);
        check("R4 basic oe", {pa_oe, pb_oe, 6'b0}, 8'hC0);
        bus_write(2'd0, 8'h6B);
        bus_read(2'd0, v);
        check("R4 basic A latch", v, 8'h6B);
    endtask

    task automatic t_bitcmd();
        logic [7:0] v;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'hC3);
        bus_write(2'd1, 8'h3C);
        bus_write(2'd2, 8'h81);
        bus_write(2'd3, 8'h0B);
        check("R6 set bit5", pc_out, 8'hA1);
        bus_write(2'd3, 8'h0E);
        check("R6 clear bit7", pc_out, 8'h21);
        bus_write(2'd3, 8'h00);
        check("R6 clear bit0", pc_out, 8'h20);
        check("R6 A kept", pa_out, 8'hC3);
        check("R6 B kept", pb_out, 8'h3C);
        bus_read(2'd3, v);
        check("R6 cfg kept", v, 8'h80);
    endtask

    task automatic t_oneshot();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd1; din = 8'h47;
        @(negedge clk); din = 8'h99;
        @(negedge clk); din = 8'hF0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check("R9 first data only", pb_out, 8'h47);
    endtask

    task automatic t_bitcmd_input();
        bus_write(2'd3, 8'h89);
        check("R10 pc_oe all in", pc_oe, 8'h00);
        bus_write(2'd3, 8'h05);
        check("R10 set bit2 on input", pc_out, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_deselect();
        t_cfg90();
        t_split_c();
        t_modes();
        t_bitcmd();
        t_oneshot();
        t_bitcmd_input();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule